// File: doc/BRIEF.md
# Charger Link Half-Duplex UART

This block runs the serial conversation between a battery-side power manager and its charger over the shared supply line. A byte handed to the transmitter is framed as an asynchronous serial word at a fixed 2 kHz bit rate, derived from the system clock. Two forms of that word leave the block: a bi-phase coded load-switch enable that the analog stage uses to pull current from the supply, and the plain serial bit stream, which goes out on a general-purpose pad.

Reception works from edge events. The analog front end turns each voltage step on the supply into a one-cycle pulse, so the block never sees a signal level or its amplitude. The receiver times the gaps between pulses against half-bit and full-bit windows, rebuilds the bits, checks the frame and presents the byte. The link is half-duplex. While a frame is being sent, incoming pulses are ignored. While a frame is being received, the transmitter accepts no byte.

The pad has three roles. By default it echoes the raw serial stream. A mode setting turns it into a three-state charge status output. When the burn-test enable is high, the pad becomes an input, and a low level on it holds the logic in reset.

Top module: `chglink_uart`

## Requirements
- R1: A byte is taken on a clock where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a frame is being sent, while a frame is being received and while the logic is held in reset. `tx_busy` rises at acceptance and falls exactly 11 bit periods later.
- R2: The raw stream uses bit periods of CLK_HZ/BIT_HZ cycles. The first bit is a start bit of 0. The eight data bits follow, least significant first. Next comes a parity bit that makes the count of ones in data plus parity odd, and last a stop bit of 1. The line rests at 1 between frames.
- R3: `load_on` is 0 (load off) when idle. It toggles at every bit boundary of a frame, including the start of the start bit, so the first bit switches the load on. It toggles once more at mid-bit for each bit of value 1. It returns to 0 when the frame ends.
- R4: With `pad_mode` at any value other than 1 and burn test off, `pad_oe` is 1. `pad_out` then equals the raw stream delayed by one clock.
- R5: With `pad_mode` = 1 and burn test off, the pad is a static status output. A fault drives it low, and a fault takes priority over completion. Completion without a fault drives it high. With neither, `pad_oe` is 0. Transmit activity does not change the pad in this mode.
- R6: With `burn_en` high, `pad_oe` is 0 one clock later. A low level on `pad_in` reaches the transmitter and receiver as a reset within four clocks: it aborts a frame in progress, drops `tx_busy` and `load_on`, and holds `tx_ready` low until the pad goes high again.
- R7: The receiver measures each gap D in cycles between `rx_edge` pulses, with H = half a bit period. A gap in [H/2, 3H/2) counts as a half gap, and a gap in [3H/2, 5H/2) counts as a full gap. A full gap with no mid-bit edge is a 0. Two half gaps make a 1. The half gap into the stop bit ends the frame.
- R8: A good frame gives a one-clock `rx_valid` pulse on the clock after the final edge, with the byte on `rx_data`. Gaps that wander by up to ±2 cycles around nominal still decode correctly.
- R9: A frame whose start bit is 1 or whose parity is even gives a one-clock `rx_err` pulse and no `rx_valid`.
- R10: If no edge arrives within 5H/2 cycles of the previous edge in a frame, `rx_err` pulses and the receiver returns to idle. A stop bit of 0 is caught this way.
- R11: An `rx_edge` that arrives while a frame is being sent, or on the clock a byte is accepted, is ignored. No result pulse comes from it, and `tx_ready` is high again as soon as the transmit frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Byte offered to the transmitter |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_busy | output | 1 | Transmit frame in progress |
| load_on | output | 1 | Load-modulation switch enable, bi-phase coded |
| rx_edge | input | 1 | One-cycle pulse per detected supply-voltage step |
| rx_valid | output | 1 | One-cycle pulse: good byte received |
| rx_data | output | 8 | Last good received byte |
| rx_err | output | 1 | One-cycle pulse: frame rejected |
| pad_mode | input | 2 | 1 = static status, other values = raw echo |
| chg_done | input | 1 | Charge complete indication |
| chg_fault | input | 1 | Charge fault indication |
| burn_en | input | 1 | Burn-test enable: pad becomes reset input |
| pad_in | input | 1 | Pad input level |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |

## Verification
The assertions take several things about the inputs for granted. `rx_edge` is a single-cycle pulse per supply step. `tx_valid` and `tx_data` stay stable from when they are raised until acceptance. `burn_en` changes only while the link is quiet. The clock-to-bit-rate ratio is even and gives a half period of at least four cycles. The stimulus keeps within these: every input is driven just after a rising edge, edges are spaced at whole-cycle gaps with at most ±2 cycles of wander, and mode and status inputs change only between frames. The one exception is a deliberate burst of edges during a transmit frame, which checks that such edges are ignored.

// File: rtl/chglink_pkg.sv
package chglink_pkg;
  localparam int FRAME_BITS = 11;
  localparam int FIELD_BITS = 10;
  localparam logic [1:0] PAD_STATUS = 2'd1;
  typedef enum logic {RX_IDLE = 1'b0, RX_RUN = 1'b1} rx_state_e;
endpackage

// File: rtl/chglink_tx.sv
module chglink_tx
  import chglink_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       raw_o,
  output logic       load_o
);
  localparam int HW = $clog2(HALF);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);

  logic [HW-1:0]         hcnt_q;
  logic                  half_q;
  logic [IW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  busy_q, raw_q, load_q;
  logic                  half_end;

  assign half_end = (hcnt_q == HW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      half_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      busy_q <= 1'b0;
      raw_q  <= 1'b1;
      load_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= {1'b1, ~^data_i, data_i, 1'b0};
        raw_q  <= 1'b0;
        load_q <= ~load_q;
        busy_q <= 1'b1;
        hcnt_q <= '0;
        half_q <= 1'b0;
        idx_q  <= '0;
      end
    end else if (half_end) begin
      hcnt_q <= '0;
      if (!half_q) begin
        half_q <= 1'b1;
        if (sh_q[0]) load_q <= ~load_q;
      end else begin
        half_q <= 1'b0;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          raw_q  <= 1'b1;
          load_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
          raw_q  <= sh_q[1];
          load_q <= ~load_q;
        end
      end
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign raw_o  = raw_q;
  assign load_o = load_q;

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> raw_q);
  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !(half_end && half_q)) |=> $stable(raw_q));
  assert_load_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !load_q);
endmodule

// File: rtl/chglink_rx.sv
module chglink_rx
  import chglink_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       edge_i,
  input  logic       block_i,
  output logic       busy_o,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       err_o
);
  localparam int LIMIT = (5 * HALF) / 2;
  localparam int TW = $clog2(LIMIT + 1);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);
  localparam logic [TW:0] H_LO = (TW+1)'(HALF / 2);
  localparam logic [TW:0] F_LO = (TW+1)'((3 * HALF) / 2);
  localparam logic [TW:0] F_HI = (TW+1)'(LIMIT);

  rx_state_e             st_q;
  logic [TW-1:0]         tmr_q;
  logic                  mid_q;
  logic [IW-1:0]         idx_q;
  logic [FIELD_BITS-1:0] sh_q;
  logic                  valid_q, err_q;
  logic [7:0]            data_q;
  logic [TW:0]           gap;
  logic                  is_half, is_full, frame_ok;

  assign gap      = {1'b0, tmr_q} + 1'b1;
  assign is_half  = (gap >= H_LO) && (gap < F_LO);
  assign is_full  = (gap >= F_LO) && (gap < F_HI);
  assign frame_ok = !sh_q[0] && (^sh_q[FIELD_BITS-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RX_IDLE;
      tmr_q   <= '0;
      mid_q   <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (edge_i && !block_i) begin
            st_q  <= RX_RUN;
            tmr_q <= '0;
            mid_q <= 1'b0;
            idx_q <= '0;
          end
        end
        default: begin
          if (edge_i) begin
            tmr_q <= '0;
            if (is_half && !mid_q) begin
              if (idx_q == LAST) begin
                st_q <= RX_IDLE;
                if (frame_ok) begin
                  valid_q <= 1'b1;
                  data_q  <= sh_q[8:1];
                end else begin
                  err_q <= 1'b1;
                end
              end else begin
                mid_q <= 1'b1;
              end
            end else if (is_half && mid_q) begin
              sh_q  <= {1'b1, sh_q[FIELD_BITS-1:1]};
              idx_q <= idx_q + 1'b1;
              mid_q <= 1'b0;
            end else if (is_full && !mid_q && idx_q != LAST) begin
              sh_q  <= {1'b0, sh_q[FIELD_BITS-1:1]};
              idx_q <= idx_q + 1'b1;
            end else begin
              err_q <= 1'b1;
              st_q  <= RX_IDLE;
            end
          end else if (tmr_q == TW'(LIMIT - 1)) begin
            err_q <= 1'b1;
            st_q  <= RX_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o  = (st_q == RX_RUN);
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign data_o  = data_q;

  assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
    !(valid_q && err_q));
  assert_timer_bound_R10: assert property (@(posedge clk) disable iff (rst)
    tmr_q < TW'(LIMIT));
  assert_blocked_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_IDLE && block_i) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/chglink_pad.sv
module chglink_pad
  import chglink_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       burn_en_i,
  input  logic       pad_in_i,
  input  logic [1:0] mode_i,
  input  logic       done_i,
  input  logic       fault_i,
  input  logic       raw_i,
  output logic       pad_out_o,
  output logic       pad_oe_o,
  output logic       burn_rst_o
);
  logic s1_q, s2_q, brst_q, out_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      brst_q <= 1'b0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      s1_q   <= pad_in_i;
      s2_q   <= s1_q;
      brst_q <= burn_en_i && !s2_q;
      if (burn_en_i) begin
        oe_q  <= 1'b0;
        out_q <= 1'b0;
      end else if (mode_i == PAD_STATUS) begin
        if (fault_i) begin
          oe_q  <= 1'b1;
          out_q <= 1'b0;
        end else if (done_i) begin
          oe_q  <= 1'b1;
          out_q <= 1'b1;
        end else begin
          oe_q  <= 1'b0;
          out_q <= 1'b0;
        end
      end else begin
        oe_q  <= 1'b1;
        out_q <= raw_i;
      end
    end
  end

  assign pad_out_o  = out_q;
  assign pad_oe_o   = oe_q;
  assign burn_rst_o = brst_q;

  assert_burn_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    burn_en_i |=> !pad_oe_o);
  assert_fault_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!burn_en_i && mode_i == PAD_STATUS && fault_i) |=> (pad_oe_o && !pad_out_o));
endmodule

// File: rtl/chglink_uart.sv
module chglink_uart #(
  parameter int CLK_HZ = 125_000_000,
  parameter int BIT_HZ = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       tx_busy,
  output logic       load_on,
  input  logic       rx_edge,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_err,
  input  logic [1:0] pad_mode,
  input  logic       chg_done,
  input  logic       chg_fault,
  input  logic       burn_en,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe
);
  localparam int CYC  = CLK_HZ / BIT_HZ;
  localparam int HALF = CYC / 2;

  logic burn_rst, core_rst, tx_raw, rx_busy, tx_start;

  assign core_rst = rst || burn_rst;
  assign tx_ready = !tx_busy && !rx_busy && !core_rst;
  assign tx_start = tx_valid && tx_ready;

  chglink_tx #(.HALF(HALF)) tx_i (
    .clk(clk), .rst(core_rst), .start_i(tx_start), .data_i(tx_data),
    .busy_o(tx_busy), .raw_o(tx_raw), .load_o(load_on)
  );

  chglink_rx #(.HALF(HALF)) rx_i (
    .clk(clk), .rst(core_rst), .edge_i(rx_edge), .block_i(tx_busy || tx_start),
    .busy_o(rx_busy), .valid_o(rx_valid), .data_o(rx_data), .err_o(rx_err)
  );

  chglink_pad pad_i (
    .clk(clk), .rst(rst), .burn_en_i(burn_en), .pad_in_i(pad_in),
    .mode_i(pad_mode), .done_i(chg_done), .fault_i(chg_fault), .raw_i(tx_raw),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .burn_rst_o(burn_rst)
  );

  assert_half_duplex_R11: assert property (@(posedge clk) disable iff (core_rst)
    !(tx_busy && rx_busy));
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (core_rst)
    (tx_valid && tx_ready) |=> tx_busy);
endmodule

// File: tb/chglink_uart_tb_top.sv
`timescale 1ns/1ps
module chglink_uart_tb_top;
  localparam int B = 16;
  localparam int H = 8;
  localparam int NB = 11;

  logic clk = 0, rst = 1;
  logic tx_valid = 0, rx_edge = 0, chg_done = 0, chg_fault = 0, burn_en = 0, pad_in = 1;
  logic [7:0] tx_data = 0;
  logic [1:0] pad_mode = 0;
  logic tx_ready, tx_busy, load_on, rx_valid, rx_err, pad_out, pad_oe;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  bit cmp_en = 0;

  always #4 clk = ~clk;

  chglink_uart #(.CLK_HZ(32000), .BIT_HZ(2000)) dut_i (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .load_on(load_on), .rx_edge(rx_edge), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_err(rx_err), .pad_mode(pad_mode), .chg_done(chg_done),
    .chg_fault(chg_fault), .burn_en(burn_en), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, evaluated between edges
  bit m_act = 0, m_pend = 0, m_lm = 0, m_raw = 1, pad_ok = 0, e_out = 0, e_oe = 0;
  int m_t = 0;
  bit [10:0] m_bits, m_next;
  int n_val = 0, n_err = 0;
  logic [7:0] last_rx;

  always @(negedge clk) begin
    if (rx_valid) begin n_val++; last_rx = rx_data; end
    if (rx_err) n_err++;
    if (rst || !cmp_en) begin
      m_act = 0; m_pend = 0; m_lm = 0; m_raw = 1; pad_ok = 0;
    end else begin
      if (m_pend) begin
        m_act = 1; m_t = 0; m_bits = m_next; m_lm = ~m_lm; m_pend = 0;
      end else if (m_act) begin
        m_t++;
        if (m_t == NB * B) begin m_act = 0; m_lm = 0; end
        else begin
          if (m_t % B == 0) m_lm = ~m_lm;
          if (m_t % B == H && m_bits[m_t / B]) m_lm = ~m_lm;
        end
      end
      m_raw = m_act ? m_bits[m_t / B] : 1'b1;
      chk(tx_busy == m_act, "R1 busy", tx_busy, m_act);
      if (m_act) chk(!tx_ready, "R1 ready low while sending", tx_ready, 0);
      chk(load_on == m_lm, "R3 load_on", load_on, m_lm);
      if (pad_ok) begin
        chk(pad_oe == e_oe, "R4/R5 pad_oe", pad_oe, e_oe);
        if (e_oe) chk(pad_out == e_out, "R2/R4/R5 pad_out", pad_out, e_out);
      end
      if (burn_en) begin e_oe = 0; e_out = 0; end
      else if (pad_mode == 2'd1) begin
        e_oe = chg_fault || chg_done; e_out = !chg_fault && chg_done;
      end else begin e_oe = 1; e_out = m_raw; end
      pad_ok = 1;
      if (tx_valid && tx_ready) begin
        m_pend = 1; m_next = {1'b1, ~^tx_data, tx_data, 1'b0};
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tx_send(input logic [7:0] d);
    @(posedge clk); #1;
    tx_valid = 1; tx_data = d;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #1;
    tx_valid = 0;
  endtask

  // emit an edge-pulse frame; bad_par flips parity, bad_stop makes stop 0
  task automatic rx_send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                         input bit jit);
    bit [10:0] f;
    int ev[$];
    int k, n, qi;
    f = {~bad_stop, (~^d) ^ bad_par, d, 1'b0};
    n = 0;
    for (int b = 0; b < NB; b++) begin
      ev.push_back(2 + b * B + (jit ? (n % 3) - 1 : 0)); n++;
      if (f[b]) begin ev.push_back(2 + b * B + H + (jit ? (n % 3) - 1 : 0)); n++; end
    end
    qi = 0;
    for (k = 0; k < NB * B + 2 * H; k++) begin
      @(posedge clk); #1;
      rx_edge = (qi < ev.size() && ev[qi] == k);
      if (rx_edge) qi++;
      if (k == 3 * B) chk(!tx_ready, "R1 ready low while receiving", tx_ready, 0);
    end
    rx_edge = 0;
    cyc(3 * B);
  endtask

  int v0, e0;

  initial begin
    cyc(1);
    @(negedge clk);
    chk(!tx_busy, "R1 reset busy", tx_busy, 0);
    chk(!load_on, "R3 reset load", load_on, 0);
    chk(!pad_oe, "R4 reset pad_oe", pad_oe, 0);
    chk(!rx_valid && !rx_err, "R8 reset rx", rx_valid, 0);
    cyc(2); rst = 0; cmp_en = 1;
    cyc(2);
    @(negedge clk) chk(tx_ready, "R1 ready after reset", tx_ready, 1);

    // R2 R3 R4: frames checked each clock by the model
    tx_send(8'hA5); cyc(NB * B + 4);
    tx_send(8'h00); cyc(NB * B + 4);
    tx_send(8'hFF); tx_send(8'h01); cyc(NB * B + 4);
    @(negedge clk) chk(tx_ready, "R1 ready after frame", tx_ready, 1);

    // R5 static status modes
    pad_mode = 2'd1; chg_done = 1; chg_fault = 0; cyc(3);
    @(negedge clk) chk(pad_oe && pad_out, "R5 done high", pad_out, 1);
    chg_fault = 1; cyc(3);
    @(negedge clk) chk(pad_oe && !pad_out, "R5 fault low", pad_out, 0);
    chg_done = 0; chg_fault = 0; cyc(3);
    @(negedge clk) chk(!pad_oe, "R5 neither hiz", pad_oe, 0);
    chg_done = 1; tx_send(8'h3C); cyc(NB * B + 4);
    chg_done = 0; pad_mode = 2'd2; cyc(3);

    // R7 R8 receive
    v0 = n_val; e0 = n_err;
    rx_send(8'h5A, 0, 0, 0);
    chk(n_val == v0 + 1 && last_rx == 8'h5A, "R7 rx 5A", last_rx, 8'h5A);
    rx_send(8'hFF, 0, 0, 0);
    chk(n_val == v0 + 2 && last_rx == 8'hFF, "R7 rx FF", last_rx, 8'hFF);
    rx_send(8'h00, 0, 0, 1);
    chk(n_val == v0 + 3 && last_rx == 8'h00, "R8 rx jitter 00", last_rx, 8'h00);
    rx_send(8'hC3, 0, 0, 1);
    chk(n_val == v0 + 4 && last_rx == 8'hC3, "R8 rx jitter C3", last_rx, 8'hC3);
    chk(n_err == e0, "R8 no errors on good frames", n_err, e0);

    // R9 parity error, R10 stop error
    rx_send(8'h81, 1, 0, 0);
    chk(n_err == e0 + 1 && n_val == v0 + 4, "R9 parity reject", n_err, e0 + 1);
    rx_send(8'h81, 0, 1, 0);
    chk(n_err == e0 + 2 && n_val == v0 + 4, "R10 stop timeout", n_err, e0 + 2);

    // R11 edges during transmit are ignored
    v0 = n_val; e0 = n_err;
    tx_send(8'h96);
    for (int i = 0; i < 6; i++) begin
      cyc(H); rx_edge = 1; cyc(1); rx_edge = 0;
    end
    cyc(NB * B);
    @(negedge clk);
    chk(tx_ready, "R11 ready after tx with edges", tx_ready, 1);
    chk(n_val == v0 && n_err == e0, "R11 no rx result", n_val + n_err, v0 + e0);

    // R6 burn-test pad reset
    cmp_en = 0;
    tx_send(8'h55); cyc(3 * B);
    burn_en = 1; cyc(3);
    @(negedge clk);
    chk(!pad_oe, "R6 pad hiz in burn", pad_oe, 0);
    chk(tx_busy, "R6 busy before pad low", tx_busy, 1);
    pad_in = 0; cyc(5);
    @(negedge clk);
    chk(!tx_busy && !load_on, "R6 abort on pad low", tx_busy, 0);
    chk(!tx_ready, "R6 ready held low", tx_ready, 0);
    pad_in = 1; cyc(6);
    @(negedge clk) chk(tx_ready, "R6 release", tx_ready, 1);
    burn_en = 0; cyc(2); cmp_en = 1;
    tx_send(8'hE7); cyc(NB * B + 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule